// File: doc/BRIEF.md
# Erased Page Verification Engine

This block confirms that one main-memory page of a serial flash device reads back as fully erased. On a start request it latches the page number, the buffer to use, the page-address shift and the size factor. It then drives a command sequencer through a request/done handshake. First it issues a ready poll. Next it transfers the page under test into the chosen on-device buffer. After that it reads the buffer back one byte at a time.

The page length is 264 bytes per unit of the size factor. The scan starts at the highest offset and moves down to offset 0. Every single-byte read is its own command, and each one is preceded by its own ready poll. The first byte that is not the erased value stops the scan and marks the page bad. A scan that reaches offset 0 without a mismatch marks the page good. A one-cycle done strobe reports the result. The bad flag and the failing offset then stay steady until the next accepted start.

Top module: `epv_scan`

## Requirements
- R1: After reset, cmd_req_o, busy_o, done_o and bad_o are 0 and fail_off_o is 0.
- R2: An accepted start first requests a ready poll (cmd_op_o = 0). Once that completes, it requests a page-to-buffer transfer (cmd_op_o = 1) with cmd_addr_o = page_i shifted left by page_bits_i, and with cmd_buf_o equal to buf_sel_i.
- R3: The page length is 264 × size_fac_i bytes. Buffer reads (cmd_op_o = 2, cmd_addr_o = byte offset) start at offset length−1 and step down by one to offset 0.
- R4: Every buffer read is immediately preceded by its own completed ready poll. No two reads are issued back to back.
- R5: A read returning any value other than 0xFF ends the scan at once. The block pulses done_o with bad_o = 1 and fail_off_o = that offset, and issues no further command.
- R6: If every byte reads 0xFF, the block pulses done_o with bad_o = 0 after exactly 264 × size_fac_i reads.
- R7: With size_fac_i = 0, the block pulses done_o with bad_o = 0 right after the transfer, issuing no buffer read.
- R8: bad_o and fail_off_o hold their values after done_o until the next accepted start, which clears them.
- R9: A start request while busy_o = 1 is ignored. The running scan keeps its page, buffer and length, and no second transfer is issued.
- R10: cmd_req_o stays high with stable cmd_op_o, cmd_addr_o and cmd_buf_o until cmd_done_i. done_o is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request (accepted when idle) |
| page_i | input | PAGE_W | Page number under test |
| buf_sel_i | input | 1 | Device buffer to use |
| page_bits_i | input | PB_W | Left shift applied to page number for the transfer address |
| size_fac_i | input | FACT_W | Size factor; page length is 264 bytes per unit |
| cmd_req_o | output | 1 | Command request to sequencer |
| cmd_op_o | output | 2 | 0 ready poll, 1 page-to-buffer transfer, 2 single-byte buffer read |
| cmd_buf_o | output | 1 | Buffer for the command |
| cmd_addr_o | output | ADDR_W | Transfer address or buffer byte offset |
| cmd_done_i | input | 1 | Command complete, one cycle |
| cmd_rdata_i | input | DATA_W | Byte returned by a buffer read, valid with cmd_done_i |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle result strobe |
| bad_o | output | 1 | Page holds a non-erased byte |
| fail_off_o | output | LEN_W | Offset of the failing byte |

## Verification
The bench uses the default parameters: a 3-bit size factor and 13-bit page numbers. It drives size factors 0, 1 and 2, which gives page lengths of 0, 264 and 528 bytes. It uses page shifts of 9 and 10, so the empty-page shortcut, two distinct lengths and two transfer address layouts are all exercised. A sequencer model with varying latency serves a byte image. Within that image it corrupts the highest offset, offset 0 and a middle offset. These cases bring the one-read abort, the full-walk abort and the mid-scan abort within reach, alongside the fully erased page.

// File: rtl/epv_pkg.sv
package epv_pkg;
  typedef enum logic [1:0] {
    OP_POLL = 2'd0,
    OP_XFER = 2'd1,
    OP_READ = 2'd2
  } cmd_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_XPOLL,
    S_XFER,
    S_RPOLL,
    S_READ
  } scan_st_e;
endpackage

// File: rtl/epv_len_calc.sv
module epv_len_calc #(
  parameter int FACT_W = 3,
  parameter int LEN_W  = FACT_W + 9
) (
  input  logic [FACT_W-1:0] fac_i,
  output logic [LEN_W-1:0]  len_o
);
  logic [LEN_W-1:0] f_ext;
  assign f_ext = LEN_W'(fac_i);
  // 264 = 256 + 8
  assign len_o = (f_ext << 8) + (f_ext << 3);
endmodule

// File: rtl/epv_byte_chk.sv
module epv_byte_chk #(
  parameter int                 DATA_W = 8,
  parameter logic [DATA_W-1:0]  ERASED = '1
) (
  input  logic [DATA_W-1:0] byte_i,
  output logic              erased_o
);
  assign erased_o = (byte_i == ERASED);
endmodule

// File: rtl/epv_scan.sv
module epv_scan
  import epv_pkg::*;
#(
  parameter int PAGE_W = 13,
  parameter int PB_W   = 4,
  parameter int FACT_W = 3,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  localparam int LEN_W = FACT_W + 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              buf_sel_i,
  input  logic [PB_W-1:0]   page_bits_i,
  input  logic [FACT_W-1:0] size_fac_i,
  output logic              cmd_req_o,
  output logic [1:0]        cmd_op_o,
  output logic              cmd_buf_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  input  logic              cmd_done_i,
  input  logic [DATA_W-1:0] cmd_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              bad_o,
  output logic [LEN_W-1:0]  fail_off_o
);

  scan_st_e          st_q;
  logic [PAGE_W-1:0] page_q;
  logic              buf_q;
  logic [PB_W-1:0]   pb_q;
  logic [FACT_W-1:0] fac_q;
  logic [LEN_W-1:0]  off_q;
  logic [LEN_W-1:0]  len;
  logic              byte_ok;

  epv_len_calc #(.FACT_W(FACT_W), .LEN_W(LEN_W)) u_len (
    .fac_i (fac_q),
    .len_o (len)
  );

  epv_byte_chk #(.DATA_W(DATA_W), .ERASED('1)) u_chk (
    .byte_i   (cmd_rdata_i),
    .erased_o (byte_ok)
  );

  always_comb begin
    cmd_req_o  = (st_q != S_IDLE);
    cmd_buf_o  = buf_q;
    cmd_op_o   = OP_POLL;
    cmd_addr_o = '0;
    unique case (st_q)
      S_XFER: begin
        cmd_op_o   = OP_XFER;
        cmd_addr_o = ADDR_W'(page_q) << pb_q;
      end
      S_READ: begin
        cmd_op_o   = OP_READ;
        cmd_addr_o = ADDR_W'(off_q);
      end
      default: ;
    endcase
  end

  assign busy_o = (st_q != S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      page_q     <= '0;
      buf_q      <= 1'b0;
      pb_q       <= '0;
      fac_q      <= '0;
      off_q      <= '0;
      done_o     <= 1'b0;
      bad_o      <= 1'b0;
      fail_off_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          page_q     <= page_i;
          buf_q      <= buf_sel_i;
          pb_q       <= page_bits_i;
          fac_q      <= size_fac_i;
          bad_o      <= 1'b0;
          fail_off_o <= '0;
          st_q       <= S_XPOLL;
        end
        S_XPOLL: if (cmd_done_i) st_q <= S_XFER;
        S_XFER: if (cmd_done_i) begin
          if (len == '0) begin
            done_o <= 1'b1;
            st_q   <= S_IDLE;
          end else begin
            off_q <= len - 1'b1;
            st_q  <= S_RPOLL;
          end
        end
        S_RPOLL: if (cmd_done_i) st_q <= S_READ;
        S_READ: if (cmd_done_i) begin
          if (!byte_ok) begin
            bad_o      <= 1'b1;
            fail_off_o <= off_q;
            done_o     <= 1'b1;
            st_q       <= S_IDLE;
          end else if (off_q == '0) begin
            done_o <= 1'b1;
            st_q   <= S_IDLE;
          end else begin
            off_q <= off_q - 1'b1;
            st_q  <= S_RPOLL;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R10: request held steady until completion
  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_req_o && !cmd_done_i |=> cmd_req_o && $stable(cmd_op_o) &&
                                 $stable(cmd_addr_o) && $stable(cmd_buf_o));

  // R10: single-cycle result strobe
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4: a read only follows a completed poll or continues itself
  a_r4_poll_before_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_req_o && cmd_op_o == OP_READ |->
      $past(cmd_req_o && cmd_op_o == OP_READ && !cmd_done_i) ||
      $past(cmd_req_o && cmd_op_o == OP_POLL && cmd_done_i));

  // R3: read offsets stay inside the page
  a_r3_off_in_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_req_o && cmd_op_o == OP_READ |-> cmd_addr_o < ADDR_W'(len));

  // R5: bad verdict only right after a non-erased read
  a_r5_bad_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && bad_o |-> $past(cmd_done_i && cmd_op_o == OP_READ && cmd_rdata_i != '1));

  // R5: no command issued in the strobe cycle
  a_r5_quiet_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cmd_req_o);

  // R8: result stable while idle without start
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(bad_o) && $stable(fail_off_o));

endmodule

// File: tb/tb_epv_scan.sv
module tb_epv_scan;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE_W = 13;
  localparam int PB_W   = 4;
  localparam int FACT_W = 3;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 8;
  localparam int LEN_W  = FACT_W + 9;

  logic clk = 0, rst_ni = 0;
  logic start_i = 0;
  logic [PAGE_W-1:0] page_i = '0;
  logic buf_sel_i = 0;
  logic [PB_W-1:0] page_bits_i = '0;
  logic [FACT_W-1:0] size_fac_i = '0;
  logic cmd_req_o, cmd_buf_o, cmd_done_i = 0;
  logic [1:0] cmd_op_o;
  logic [ADDR_W-1:0] cmd_addr_o;
  logic [DATA_W-1:0] cmd_rdata_i = '0;
  logic busy_o, done_o, bad_o;
  logic [LEN_W-1:0] fail_off_o;

  int checks = 0, failures = 0;
  int cyc = 0;

  // sequencer model state
  logic [7:0] img [0:2047];
  int lat_cnt = 0, n_cmd = 0;
  int n_xfer = 0, n_read = 0, seq_err = 0;
  int exp_off = 0;
  int last_op = -1;
  logic [ADDR_W-1:0] exp_xaddr = '0;
  logic exp_buf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  epv_scan #(.PAGE_W(PAGE_W), .PB_W(PB_W), .FACT_W(FACT_W),
             .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .page_i(page_i),
    .buf_sel_i(buf_sel_i), .page_bits_i(page_bits_i), .size_fac_i(size_fac_i),
    .cmd_req_o(cmd_req_o), .cmd_op_o(cmd_op_o), .cmd_buf_o(cmd_buf_o),
    .cmd_addr_o(cmd_addr_o), .cmd_done_i(cmd_done_i), .cmd_rdata_i(cmd_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .bad_o(bad_o), .fail_off_o(fail_off_o));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  // sequencer model: variable latency, one-cycle done
  initial begin
    forever begin
      @(negedge clk);
      cmd_done_i = 0;
      if (rst_ni && cmd_req_o) begin
        if (lat_cnt >= (n_cmd % 3)) begin
          lat_cnt = 0;
          n_cmd++;
          case (cmd_op_o)
            2'd1: begin
              n_xfer++;
              if (last_op != 0 || cmd_addr_o != exp_xaddr || cmd_buf_o != exp_buf) seq_err++;
            end
            2'd2: begin
              n_read++;
              if (last_op != 0 || int'(cmd_addr_o) != exp_off || cmd_buf_o != exp_buf) seq_err++;
              cmd_rdata_i = img[cmd_addr_o[10:0]];
              exp_off--;
            end
            default: ;
          endcase
          last_op = int'(cmd_op_o);
          cmd_done_i = 1;
        end else begin
          lat_cnt++;
        end
      end
    end
  end

  task automatic run_case(input string name, input int page, input int pb,
                          input int fac, input bit bsel, input int bad_at,
                          input bit mid_start);
    int len = 264 * fac;
    int exp_reads;
    int wait_c = 0;
    for (int i = 0; i < 2048; i++) img[i] = 8'hFF;
    if (bad_at >= 0) img[bad_at] = 8'h7E;
    n_xfer = 0; n_read = 0; seq_err = 0; last_op = -1;
    exp_off = len - 1;
    exp_xaddr = ADDR_W'(page) << pb;
    exp_buf = bsel;
    exp_reads = (bad_at >= 0) ? (len - bad_at) : len;
    @(negedge clk);
    page_i = PAGE_W'(page); page_bits_i = PB_W'(pb);
    size_fac_i = FACT_W'(fac); buf_sel_i = bsel;
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    check(busy_o == 1 && bad_o == 0, "R8", {name, " busy and cleared at start"},
          int'(bad_o), 0);
    if (mid_start) begin
      repeat (40) @(negedge clk);
      page_i = PAGE_W'(page + 3); buf_sel_i = ~bsel; size_fac_i = FACT_W'(fac + 1);
      start_i = 1;
      @(negedge clk);
      start_i = 0;
    end
    while (!done_o && wait_c < 20000) begin
      @(negedge clk);
      wait_c++;
    end
    check(done_o == 1, "R10", {name, " done strobe"}, int'(done_o), 1);
    check(bad_o == (bad_at >= 0), (bad_at >= 0) ? "R5" : "R6", {name, " bad flag"},
          int'(bad_o), int'(bad_at >= 0));
    if (bad_at >= 0)
      check(int'(fail_off_o) == bad_at, "R5", {name, " fail offset"},
            int'(fail_off_o), bad_at);
    check(n_read == exp_reads, "R3", {name, " read count"}, n_read, exp_reads);
    check(n_xfer == 1, mid_start ? "R9" : "R2", {name, " transfer count"}, n_xfer, 1);
    check(seq_err == 0, "R4", {name, " command order/address/buffer"}, seq_err, 0);
    @(negedge clk);
    check(done_o == 0, "R10", {name, " done one cycle"}, int'(done_o), 0);
    repeat (5) @(negedge clk);
    check(cmd_req_o == 0 && n_read == exp_reads, "R5",
          {name, " no command after done"}, n_read, exp_reads);
    check(bad_o == (bad_at >= 0) && (bad_at < 0 || int'(fail_off_o) == bad_at),
          "R8", {name, " result held"}, int'(fail_off_o), bad_at < 0 ? 0 : bad_at);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cmd_req_o == 0 && busy_o == 0 && done_o == 0 && bad_o == 0 && fail_off_o == 0,
          "R1", "reset outputs", int'(cmd_req_o) + int'(busy_o) + int'(bad_o), 0);
    rst_ni = 1;
    repeat (2) @(negedge clk);
    run_case("erased_f1",  5,  9, 1, 0, -1,  0);   // R6
    run_case("bad_last",   7,  9, 1, 1, 263, 0);   // R5 highest offset
    run_case("bad_first", 12, 10, 2, 0, 0,   0);   // R5 offset 0, R3 len 528
    run_case("bad_mid",   33, 10, 2, 1, 300, 0);   // R5 mid
    run_case("erased_f2", 100, 9, 2, 1, -1,  0);   // R6 528 reads
    run_case("empty_f0",   9,  9, 0, 0, -1,  0);   // R7 no reads
    run_case("busy_start", 21, 9, 1, 0, 130, 1);   // R9 ignored start
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule